// File: doc/BRIEF.md
# Split or Unified Match Counter

This block is the counting core of a general timer. One configuration input chooses between two 16-bit counters that run on their own (a low half and a high half) and one 32-bit counter made from both halves. Each half holds a small bank of match registers, and each match register has a reload register behind it. On a reload event the match value is refreshed from its reload register, so software can stage the next period while the current one runs.

A count-enable strobe comes from an external clock qualifier. A counter advances only on cycles where that strobe and the counter's own run bit are both high. Match register 0 can act as an automatic limit. In up-only mode the limit clears the count. In up/down mode the limit turns the count around, and the count turns upward again when it reaches zero on the way down. In 32-bit mode the low-half control bits govern the whole counter, and the match comparison uses the high and low match registers joined together.

Top module: `split_match_counter`

## Requirements
- R1: After a synchronous active-low reset, both counts are 0, all match flags are 0, both direction flags read up (0), and all match and reload registers hold 0.
- R2: With `unify` low, each half advances by one on a clock edge only when `cnt_en` and that half's run bit are both high, and otherwise holds. One half has no effect on the other.
- R3: With `unify` high, {`count_hi`,`count_lo`} acts as one 32-bit counter. The carry passes from the low half into the high half, and only `cnt_en` and `run_lo` enable it.
- R4: In up-only mode with the auto-limit bit set, an enabled edge at which the count equals match register 0 loads 0 into the count. With the bit clear, the count moves past that value.
- R5: In up-only mode, an enabled edge at the all-ones count returns the count to 0.
- R6: In up/down mode, an enabled upward edge at a limit sets the direction flag to down and loads count-1. An enabled downward edge at 0 sets the direction flag to up and loads 1.
- R7: Match flag k goes high for the one cycle after an enabled edge at which the count equals match register k. In 32-bit mode the comparison uses {high match k, low match k}, flag k appears on `match_lo`, and `match_hi` stays 0.
- R8: On a reload event (the limit edge in up-only mode, or the down-at-zero edge in up/down mode), each match register of the half takes the value of its reload register, unless that half's no-reload bit is set.
- R9: In 32-bit mode, `run_hi`, `bidir_hi`, `autolim_hi` and `norld_hi` have no effect, and `dir_down_hi` reads 0.
- R10: An edge with `wr_en` high writes `wr_data` into one register. `wr_hi` selects the half (0 low, 1 high), `wr_rld` selects the register (0 match, 1 reload) and `wr_idx` selects the index. The new value is used from the next edge onward. A write takes priority over a reload of the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count-enable strobe from the clock qualifier |
| unify | input | 1 | 1: one 32-bit counter, 0: two 16-bit counters |
| run_lo | input | 1 | Low half (or 32-bit counter) run bit |
| run_hi | input | 1 | High half run bit |
| bidir_lo | input | 1 | Low half up/down mode |
| bidir_hi | input | 1 | High half up/down mode |
| autolim_lo | input | 1 | Low half: match 0 acts as limit |
| autolim_hi | input | 1 | High half: match 0 acts as limit |
| norld_lo | input | 1 | Low half: suppress reload of match registers |
| norld_hi | input | 1 | High half: suppress reload of match registers |
| wr_en | input | 1 | Register write strobe |
| wr_hi | input | 1 | Write half select (0 low, 1 high) |
| wr_rld | input | 1 | Write target (0 match, 1 reload) |
| wr_idx | input | 1 | Match register index |
| wr_data | input | 16 | Write data |
| count_lo | output | 16 | Low half count |
| count_hi | output | 16 | High half count |
| match_lo | output | 2 | Low half (or 32-bit) match flags |
| match_hi | output | 2 | High half match flags |
| dir_down_lo | output | 1 | Low half (or 32-bit) direction, 1 = down |
| dir_down_hi | output | 1 | High half direction, 1 = down |

## Verification
The hardest cases to reach are the carry from the low half into the high half in 32-bit mode and the all-ones wrap of a half. No port can preset the count, so the bench holds the enable high for 65535 edges to bring the low half to all ones, then checks the following edges one at a time. The effect of a reload is also hard to see, because match registers cannot be read. The bench therefore sets a reload value different from the current match value and checks the count at which the next limit or turnaround occurs.

// File: rtl/smc_pkg.sv
// Shared types for the split/unified match counter.
package smc_pkg;

    // Half selector used on the write port and for bank indexing.
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    // Per-half control bundle.
    typedef struct packed {
        logic run;
        logic bidir;
        logic autolim;
        logic norld;
    } half_ctrl_t;

endpackage

// File: rtl/smc_match_bank.sv
// Match/reload register bank for one counter half.
// Holds NUM_MATCH match registers, each with a reload register behind it.
// Assumes: a write to a match register wins over a reload in the same cycle.
module smc_match_bank #(
    parameter int W         = 16,
    parameter int NUM_MATCH = 2,
    parameter int IDX_W     = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        wr_rld,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [W-1:0]                wr_data,
    input  logic                        reload_evt,
    input  logic                        norld,
    output logic [NUM_MATCH-1:0][W-1:0] match_q
);

    logic [NUM_MATCH-1:0][W-1:0] reload_q;

    for (genvar k = 0; k < NUM_MATCH; k++) begin : g_reg
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(k));

        // Match register: write port first, then reload event.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                match_q[k] <= '0;
            end else if (sel && !wr_rld) begin
                match_q[k] <= wr_data;
            end else if (reload_evt && !norld) begin
                match_q[k] <= reload_q[k];
            end
        end

        // Reload register: written only through the write port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reload_q[k] <= '0;
            end else if (sel && wr_rld) begin
                reload_q[k] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/smc_step.sv
// Next-state logic for one counter of width W.
// Handles up-only (clear at limit) and up/down (turn at limit, turn at zero).
// Assumes: limit is only honoured while counting up.
module smc_step #(
    parameter int W = 16
) (
    input  logic         en,
    input  logic         bidir,
    input  logic         dir_down,
    input  logic         limit,
    input  logic [W-1:0] count,
    output logic [W-1:0] count_nxt,
    output logic         dir_nxt,
    output logic         reload
);

    localparam logic [W-1:0] ONE = W'(1);

    logic at_zero;
    assign at_zero = (count == '0);

    // Compute next count, direction and reload event.
    always_comb begin
        count_nxt = count;
        dir_nxt   = dir_down;
        reload    = 1'b0;
        if (en) begin
            if (!bidir) begin
                dir_nxt = 1'b0;
                if (limit) begin
                    count_nxt = '0;
                    reload    = 1'b1;
                end else begin
                    count_nxt = count + ONE;
                end
            end else if (!dir_down) begin
                if (limit) begin
                    dir_nxt   = 1'b1;
                    count_nxt = at_zero ? '0 : count - ONE;
                end else begin
                    count_nxt = count + ONE;
                end
            end else begin
                if (at_zero) begin
                    dir_nxt   = 1'b0;
                    count_nxt = ONE;
                    reload    = 1'b1;
                end else begin
                    count_nxt = count - ONE;
                end
            end
        end
    end

endmodule

// File: rtl/split_match_counter.sv
// Split or unified match counter.
// Two HALF_W counters, or one 2*HALF_W counter when unify is high.
// Each half has NUM_MATCH match registers with reload shadows; match 0 may
// act as an automatic limit. In unified mode the low-half controls apply.
// Assumes: cnt_en is already synchronous to clk.
module split_match_counter #(
    parameter int HALF_W    = 16,
    parameter int NUM_MATCH = 2,
    localparam int IDX_W    = (NUM_MATCH > 1) ? $clog2(NUM_MATCH) : 1,
    localparam int FULL_W   = 2 * HALF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cnt_en,
    input  logic                 unify,
    input  logic                 run_lo,
    input  logic                 run_hi,
    input  logic                 bidir_lo,
    input  logic                 bidir_hi,
    input  logic                 autolim_lo,
    input  logic                 autolim_hi,
    input  logic                 norld_lo,
    input  logic                 norld_hi,
    input  logic                 wr_en,
    input  logic                 wr_hi,
    input  logic                 wr_rld,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [HALF_W-1:0]    wr_data,
    output logic [HALF_W-1:0]    count_lo,
    output logic [HALF_W-1:0]    count_hi,
    output logic [NUM_MATCH-1:0] match_lo,
    output logic [NUM_MATCH-1:0] match_hi,
    output logic                 dir_down_lo,
    output logic                 dir_down_hi
);
    import smc_pkg::*;

    half_ctrl_t ctl_lo, ctl_hi;
    assign ctl_lo = '{run: run_lo, bidir: bidir_lo, autolim: autolim_lo, norld: norld_lo};
    assign ctl_hi = '{run: run_hi, bidir: bidir_hi, autolim: autolim_hi, norld: norld_hi};

    logic [1:0][NUM_MATCH-1:0][HALF_W-1:0] mq;
    logic [1:0] bank_rl, bank_norld;

    logic [NUM_MATCH-1:0] hit_lo, hit_hi, hit_u;
    logic en_lo, en_hi, lim_lo, lim_hi, lim_u;
    logic [HALF_W-1:0] nxt_lo, nxt_hi;
    logic [FULL_W-1:0] nxt_u;
    logic nd_lo, nd_hi, nd_u, rl_lo, rl_hi, rl_u;

    // One match bank per half.
    for (genvar h = 0; h < 2; h++) begin : g_bank
        smc_match_bank #(.W(HALF_W), .NUM_MATCH(NUM_MATCH), .IDX_W(IDX_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_en && (wr_hi == 1'(h))),
            .wr_rld     (wr_rld),
            .wr_idx     (wr_idx),
            .wr_data    (wr_data),
            .reload_evt (bank_rl[h]),
            .norld      (bank_norld[h]),
            .match_q    (mq[h])
        );
    end

    // Compare each count with every match register.
    always_comb begin
        for (int k = 0; k < NUM_MATCH; k++) begin
            hit_lo[k] = (count_lo == mq[HALF_LO][k]);
            hit_hi[k] = (count_hi == mq[HALF_HI][k]);
            hit_u[k]  = ({count_hi, count_lo} == {mq[HALF_HI][k], mq[HALF_LO][k]});
        end
    end

    // Enables and limit conditions per mode.
    assign en_lo  = cnt_en && ctl_lo.run;
    assign en_hi  = cnt_en && ctl_hi.run;
    assign lim_lo = (ctl_lo.autolim && hit_lo[0]) || (&count_lo);
    assign lim_hi = (ctl_hi.autolim && hit_hi[0]) || (&count_hi);
    assign lim_u  = (ctl_lo.autolim && hit_u[0]) || (&{count_hi, count_lo});

    smc_step #(.W(FULL_W)) u_step_u (
        .en (en_lo), .bidir (ctl_lo.bidir), .dir_down (dir_down_lo), .limit (lim_u),
        .count ({count_hi, count_lo}), .count_nxt (nxt_u), .dir_nxt (nd_u), .reload (rl_u)
    );
    smc_step #(.W(HALF_W)) u_step_lo (
        .en (en_lo), .bidir (ctl_lo.bidir), .dir_down (dir_down_lo), .limit (lim_lo),
        .count (count_lo), .count_nxt (nxt_lo), .dir_nxt (nd_lo), .reload (rl_lo)
    );
    smc_step #(.W(HALF_W)) u_step_hi (
        .en (en_hi), .bidir (ctl_hi.bidir), .dir_down (dir_down_hi), .limit (lim_hi),
        .count (count_hi), .count_nxt (nxt_hi), .dir_nxt (nd_hi), .reload (rl_hi)
    );

    // Route reload events and no-reload bits to the banks by mode.
    always_comb begin
        bank_rl[HALF_LO]    = unify ? rl_u : rl_lo;
        bank_rl[HALF_HI]    = unify ? rl_u : rl_hi;
        bank_norld[HALF_LO] = ctl_lo.norld;
        bank_norld[HALF_HI] = unify ? ctl_lo.norld : ctl_hi.norld;
    end

    // Count, direction and match flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_lo    <= '0;
            count_hi    <= '0;
            dir_down_lo <= 1'b0;
            dir_down_hi <= 1'b0;
            match_lo    <= '0;
            match_hi    <= '0;
        end else if (unify) begin
            {count_hi, count_lo} <= nxt_u;
            dir_down_lo <= nd_u;
            dir_down_hi <= 1'b0;
            match_lo    <= en_lo ? hit_u : '0;
            match_hi    <= '0;
        end else begin
            count_lo    <= nxt_lo;
            count_hi    <= nxt_hi;
            dir_down_lo <= nd_lo;
            dir_down_hi <= nd_hi;
            match_lo    <= en_lo ? hit_lo : '0;
            match_hi    <= en_hi ? hit_hi : '0;
        end
    end

endmodule

// File: rtl/smc_checker.sv
// Port-level properties for split_match_counter, attached with bind.
module smc_checker #(
    parameter int HALF_W    = 16,
    parameter int NUM_MATCH = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cnt_en,
    input logic                 unify,
    input logic                 run_lo,
    input logic                 run_hi,
    input logic                 bidir_lo,
    input logic [HALF_W-1:0]    count_lo,
    input logic [HALF_W-1:0]    count_hi,
    input logic [NUM_MATCH-1:0] match_hi,
    input logic                 dir_down_lo,
    input logic                 dir_down_hi
);

    localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

    // R2: low count holds without its enable.
    a_r2_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_en && run_lo) |=> $stable(count_lo));

    // R2: high count holds without its enable in split mode.
    a_r2_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!unify && !(cnt_en && run_hi)) |=> $stable(count_hi));

    // R3, R9: in unified mode the high half follows the low-half enable only.
    a_r3_hi_follows_lo_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (unify && !(cnt_en && run_lo)) |=> $stable(count_hi));

    // R4: in split up-only mode the low count steps by one or clears.
    a_r4_step_or_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!unify && cnt_en && run_lo && !bidir_lo)
        |=> ((count_lo == $past(count_lo) + ONE) || (count_lo == '0)));

    // R6: up-only mode leaves the direction flag at up.
    a_r6_unidir_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && run_lo && !bidir_lo) |=> !dir_down_lo);

    // R9: high direction flag idle in unified mode.
    a_r9_hi_dir_idle: assert property (@(posedge clk) disable iff (!rst_n)
        unify |=> !dir_down_hi);

    // R7: high match flags idle in unified mode.
    a_r7_hi_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
        unify |=> (match_hi == '0));

endmodule

bind split_match_counter smc_checker #(.HALF_W(HALF_W), .NUM_MATCH(NUM_MATCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_en      (cnt_en),
    .unify       (unify),
    .run_lo      (run_lo),
    .run_hi      (run_hi),
    .bidir_lo    (bidir_lo),
    .count_lo    (count_lo),
    .count_hi    (count_hi),
    .match_hi    (match_hi),
    .dir_down_lo (dir_down_lo),
    .dir_down_hi (dir_down_hi)
);

// File: tb/sim_split_match_counter.sv
`timescale 1ns/1ps
// Self-checking bench: vector table for split counting, then directed tests.
module sim_split_match_counter;

    logic clk = 1'b0;
    logic rst_n, cnt_en, unify, run_lo, run_hi, bidir_lo, bidir_hi;
    logic autolim_lo, autolim_hi, norld_lo, norld_hi;
    logic wr_en, wr_hi, wr_rld;
    logic [0:0]  wr_idx;
    logic [15:0] wr_data, count_lo, count_hi;
    logic [1:0]  match_lo, match_hi;
    logic dir_down_lo, dir_down_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    split_match_counter u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .unify(unify),
        .run_lo(run_lo), .run_hi(run_hi), .bidir_lo(bidir_lo), .bidir_hi(bidir_hi),
        .autolim_lo(autolim_lo), .autolim_hi(autolim_hi),
        .norld_lo(norld_lo), .norld_hi(norld_hi),
        .wr_en(wr_en), .wr_hi(wr_hi), .wr_rld(wr_rld), .wr_idx(wr_idx), .wr_data(wr_data),
        .count_lo(count_lo), .count_hi(count_hi), .match_lo(match_lo), .match_hi(match_hi),
        .dir_down_lo(dir_down_lo), .dir_down_hi(dir_down_hi)
    );

    // {cnt_en, run_lo, run_hi, expected count_lo, expected count_hi}
    localparam logic [34:0] VEC [0:5] = '{
        {1'b1, 1'b1, 1'b1, 16'd1, 16'd1},
        {1'b1, 1'b1, 1'b0, 16'd2, 16'd1},
        {1'b0, 1'b1, 1'b1, 16'd2, 16'd1},
        {1'b1, 1'b0, 1'b1, 16'd2, 16'd2},
        {1'b1, 1'b1, 1'b1, 16'd3, 16'd3},
        {1'b1, 1'b1, 1'b0, 16'd4, 16'd3}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cnt_en = 1'b0; unify = 1'b0; run_lo = 1'b0; run_hi = 1'b0;
        bidir_lo = 1'b0; bidir_hi = 1'b0; autolim_lo = 1'b0; autolim_hi = 1'b0;
        norld_lo = 1'b0; norld_hi = 1'b0;
        wr_en = 1'b0; wr_hi = 1'b0; wr_rld = 1'b0; wr_idx = 1'b0; wr_data = 16'h0;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic hi, input logic rld, input int idx, input logic [15:0] d);
        cnt_en = 1'b0;
        wr_en = 1'b1; wr_hi = hi; wr_rld = rld; wr_idx = 1'(idx); wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        #1;
        do_reset();
        // R1: reset state
        chk("R1 counts", {count_hi, count_lo}, 32'h0);
        chk("R1 flags/dir", {28'h0, match_lo, match_hi}, 32'h0);
        chk("R1 dir", {30'h0, dir_down_lo, dir_down_hi}, 32'h0);

        // R2: split mode enable table
        for (int v = 0; v < 6; v++) begin
            cnt_en = VEC[v][34]; run_lo = VEC[v][33]; run_hi = VEC[v][32];
            step(1);
            chk($sformatf("R2 vector %0d", v), {count_lo, count_hi}, VEC[v][31:0]);
        end

        // R4/R7/R8/R10: auto-limit in up-only mode with reload (low half)
        do_reset();
        wr(1'b0, 1'b0, 0, 16'd3);
        wr(1'b0, 1'b1, 0, 16'd5);
        wr(1'b0, 1'b0, 1, 16'd2);
        wr(1'b0, 1'b1, 1, 16'd2);
        autolim_lo = 1'b1; run_lo = 1'b1; cnt_en = 1'b1;
        step(3);
        chk("R7 R10 flag for match 1", {14'h0, match_lo, count_lo}, {14'h0, 2'b10, 16'd3});
        step(1);
        chk("R4 clear at match 0", {14'h0, match_lo, count_lo}, {14'h0, 2'b01, 16'd0});
        step(5);
        chk("R8 reloaded limit reached", {16'h0, count_lo}, 32'd5);
        step(1);
        chk("R8 clear at reloaded limit", {16'h0, count_lo}, 32'd0);
        cnt_en = 1'b0; norld_lo = 1'b1;
        wr(1'b0, 1'b1, 0, 16'd2);
        cnt_en = 1'b1;
        step(9);
        chk("R8 no-reload keeps match", {16'h0, count_lo}, 32'd3);
        chk("R2 high half idle", {16'h0, count_hi}, 32'd0);
        autolim_lo = 1'b0;
        step(3);
        chk("R4 passes match without auto-limit", {16'h0, count_lo}, 32'd6);

        // R6/R8: up/down mode on the high half
        do_reset();
        wr(1'b1, 1'b0, 0, 16'd3);
        wr(1'b1, 1'b1, 0, 16'd2);
        run_hi = 1'b1; bidir_hi = 1'b1; autolim_hi = 1'b1; cnt_en = 1'b1;
        step(4);
        chk("R6 turn down at limit", {15'h0, dir_down_hi, count_hi}, {15'h0, 1'b1, 16'd2});
        step(3);
        chk("R6 turn up at zero", {15'h0, dir_down_hi, count_hi}, {15'h0, 1'b0, 16'd1});
        step(2);
        chk("R8 reload at zero in up/down", {15'h0, dir_down_hi, count_hi}, {15'h0, 1'b1, 16'd1});
        chk("R2 low half idle", {16'h0, count_lo}, 32'd0);

        // R3/R9/R7: unified 32-bit counter
        do_reset();
        wr(1'b0, 1'b0, 0, 16'h0002);
        wr(1'b1, 1'b0, 0, 16'h0001);
        unify = 1'b1; run_lo = 1'b1; run_hi = 1'b0; autolim_lo = 1'b1; norld_lo = 1'b1;
        autolim_hi = 1'b1; bidir_hi = 1'b1; cnt_en = 1'b1;
        step(65535);
        chk("R3 R9 low half full", {count_hi, count_lo}, 32'h0000_FFFF);
        step(1);
        chk("R3 carry into high half", {count_hi, count_lo}, 32'h0001_0000);
        step(2);
        chk("R9 high controls ignored", {count_hi, count_lo}, 32'h0001_0002);
        step(1);
        chk("R7 unified limit and flag", {count_hi, count_lo}, 32'h0);
        chk("R7 unified flags", {28'h0, match_lo, match_hi}, {28'h0, 2'b01, 2'b00});
        chk("R9 high dir idle", {31'h0, dir_down_hi}, 32'h0);

        // R5: all-ones wrap in split up-only mode
        do_reset();
        run_lo = 1'b1; cnt_en = 1'b1;
        step(65535);
        chk("R5 low half at all ones", {16'h0, count_lo}, 32'h0000_FFFF);
        step(1);
        chk("R5 wrap to zero", {16'h0, count_lo}, 32'h0);

        done = 1'b1;
        summary();
    end

endmodule